// File: doc/BRIEF.md
# Programmable Temperature Threshold Comparator Bank

This block watches a stream of signed temperature samples and compares every new sample against a bank of independently programmed thresholds. The default bank has six comparators. A sample and its thresholds are 16-bit two's-complement values in steps of 1/64 degree. Each comparator has its own 2-bit direction code. Code 0 tests whether the sample is at or below the threshold, and code 1 tests whether it is at or above. Codes 2 and 3 are reserved and never match.

For each comparator the block keeps two bits. The live status bit gives the result for the most recent sample. The sticky flag is set by any match and stays set until software clears it with a per-comparator clear strobe. One interrupt line is formed from all sticky flags that are enabled. Software can drop an enable bit while it reprograms a threshold and raise it again afterwards. A data-ready flag records that a sample has arrived since it was last cleared. The threshold, mode and enable values come in as plain input vectors. Comparator `i` uses bits `[16*i+15:16*i]` of the threshold bus and bits `[2*i+1:2*i]` of the mode bus.

Top module: `tcmp_bank`

## Requirements
- R1: After reset, every live status bit, every sticky flag, the data-ready flag and the interrupt line are 0.
- R2: With mode code 0, a comparator matches when the signed sample is less than or equal to its threshold, and an equal value matches.
- R3: With mode code 1, a comparator matches when the signed sample is greater than or equal to its threshold, and an equal value matches.
- R4: With mode code 2 or 3, a comparator never matches: its live status goes to 0 on each sample and its sticky flag is never set.
- R5: A comparison is made only in a cycle where `smp_vld` is high. Between samples the live status holds its last value, whatever the sample data does.
- R6: A match sets the comparator's sticky flag on the next clock. The flag stays set through later samples that do not match.
- R7: A high `flag_clr[i]` clears sticky flag `i` on the next clock. When a match on comparator `i` happens in the same cycle, the match wins and the flag stays set.
- R8: `irq` is high exactly when some comparator has both its sticky flag and its `irq_en` bit set. It follows `irq_en` in the same cycle.
- R9: `data_rdy` sets on the clock after any valid sample and stays set until `rdy_clr`. A valid sample in the same cycle as `rdy_clr` keeps it set.
- R10: Comparisons are signed, so negative samples and negative thresholds order correctly against positive ones.
- R11: Comparators are independent: clearing or matching one comparator leaves the flags of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld | input | 1 | Sample valid strobe |
| smp_data | input | 16 | Signed temperature sample, 1/64 degree units |
| thr_bus | input | 96 | Packed thresholds, 16 bits per comparator |
| mode_bus | input | 12 | Packed direction codes, 2 bits per comparator |
| irq_en | input | 6 | Interrupt enable per comparator |
| flag_clr | input | 6 | Sticky flag clear strobe per comparator |
| rdy_clr | input | 1 | Data-ready clear strobe |
| live_stat | output | 6 | Result of the latest comparison per comparator |
| flag | output | 6 | Sticky match flag per comparator |
| data_rdy | output | 1 | Sample-arrived flag |
| irq | output | 1 | Combined interrupt |

## Verification
Live status, sticky flags and data-ready are registered. Each one changes at the first rising edge that samples the strobe or clear causing it, so its new value can be seen one clock after the stimulus is applied. The interrupt line is combinational from the flags and enables. It therefore reflects a change of `irq_en` in the same cycle, and a new flag one clock after the match. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge, and every output is compared on the next falling edge. Directed checks at the same points cover the mode and sign corner cases.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  localparam int unsigned DIR_W = 2;

  typedef enum logic [DIR_W-1:0] {
    DIR_AT_OR_BELOW = 2'd0,
    DIR_AT_OR_ABOVE = 2'd1,
    DIR_RSV_2       = 2'd2,
    DIR_RSV_3       = 2'd3
  } tcmp_dir_e;

endpackage

// File: rtl/tcmp_rst_sync.sv
module tcmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tcmp_cell.sv
module tcmp_cell
  import tcmp_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [DW-1:0]    smp_data,
  input  logic [DW-1:0]    thr,
  input  logic [DIR_W-1:0] mode,
  input  logic             clr,
  output logic             live,
  output logic             flag
);

  logic      below_or_eq;
  logic      above_or_eq;
  logic      hit;
  tcmp_dir_e dir;
  logic      live_q, live_nxt, live_en;
  logic      flag_q, flag_nxt, flag_en;

  assign dir = tcmp_dir_e'(mode);

  always_comb begin
    below_or_eq = $signed(smp_data) <= $signed(thr);
    above_or_eq = $signed(smp_data) >= $signed(thr);
    unique case (dir)
      DIR_AT_OR_BELOW: hit = below_or_eq;
      DIR_AT_OR_ABOVE: hit = above_or_eq;
      default:         hit = 1'b0;
    endcase
  end

  // live status: load enable is the sample strobe
  always_comb begin
    live_en  = smp_vld;
    live_nxt = hit;
  end

  // sticky flag: a new match takes priority over a clear
  always_comb begin
    flag_en  = (smp_vld && hit) || clr;
    flag_nxt = smp_vld && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else if (live_en) begin
      live_q <= live_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_nxt;
    end
  end

  assign live = live_q;
  assign flag = flag_q;

  p_hold_between_samples_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(live_q));

  p_reserved_mode_no_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && mode[1]) |=> (!live_q && $stable(flag_q)));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  p_clear_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !smp_vld) |=> !flag_q);

  p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && live_nxt) |=> (flag_q && live_q));

endmodule

// File: rtl/tcmp_rdy_flag.sv
module tcmp_rdy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic rdy_clr,
  output logic data_rdy
);

  logic rdy_q, rdy_nxt, rdy_en;

  always_comb begin
    rdy_en  = smp_vld || rdy_clr;
    rdy_nxt = smp_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
    end else if (rdy_en) begin
      rdy_q <= rdy_nxt;
    end
  end

  assign data_rdy = rdy_q;

  p_rdy_on_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> rdy_q);

  p_rdy_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_clr && !smp_vld) |=> !rdy_q);

endmodule

// File: rtl/tcmp_irq_merge.sv
module tcmp_irq_merge #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] irq_en,
  output logic         irq
);

  logic [N-1:0] armed;

  always_comb begin
    armed = flag & irq_en;
    irq   = |armed;
  end

endmodule

// File: rtl/tcmp_bank.sv
module tcmp_bank
  import tcmp_pkg::*;
#(
  parameter int unsigned N  = 6,
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DW-1:0]     smp_data,
  input  logic [N*DW-1:0]   thr_bus,
  input  logic [N*DIR_W-1:0] mode_bus,
  input  logic [N-1:0]      irq_en,
  input  logic [N-1:0]      flag_clr,
  input  logic              rdy_clr,
  output logic [N-1:0]      live_stat,
  output logic [N-1:0]      flag,
  output logic              data_rdy,
  output logic              irq
);

  localparam int unsigned SYNC_STAGES = 2;

  logic rst_int_n;

  tcmp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar g = 0; g < N; g++) begin : g_cell
    tcmp_cell #(.DW(DW)) u_cell (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .smp_vld  (smp_vld),
      .smp_data (smp_data),
      .thr      (thr_bus[g*DW +: DW]),
      .mode     (mode_bus[g*DIR_W +: DIR_W]),
      .clr      (flag_clr[g]),
      .live     (live_stat[g]),
      .flag     (flag[g])
    );
  end

  tcmp_rdy_flag u_rdy (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .smp_vld  (smp_vld),
    .rdy_clr  (rdy_clr),
    .data_rdy (data_rdy)
  );

  tcmp_irq_merge #(.N(N)) u_irq (
    .flag   (flag),
    .irq_en (irq_en),
    .irq    (irq)
  );

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (|flag));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_en == '0) |-> !irq);

endmodule

// File: tb/tcmp_bank_tb_top.sv
module tcmp_bank_tb_top;

  localparam int N  = 6;
  localparam int DW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_vld = 1'b0;
  logic [DW-1:0]     smp_data = '0;
  logic [N*DW-1:0]   thr_bus;
  logic [N*2-1:0]    mode_bus;
  logic [N-1:0]      irq_en = '0;
  logic [N-1:0]      flag_clr = '0;
  logic              rdy_clr = 1'b0;
  logic [N-1:0]      live_stat;
  logic [N-1:0]      flag;
  logic              data_rdy;
  logic              irq;

  logic signed [15:0] thr_a [N];
  logic [1:0]         mode_a [N];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit chk_on = 1'b0;

  // reference model state
  bit m_live [N];
  bit m_flag [N];
  bit m_rdy;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      thr_bus[i*DW +: DW] = thr_a[i];
      mode_bus[i*2 +: 2]  = mode_a[i];
    end
  end

  tcmp_bank #(.N(N), .DW(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .thr_bus   (thr_bus),
    .mode_bus  (mode_bus),
    .irq_en    (irq_en),
    .flag_clr  (flag_clr),
    .rdy_clr   (rdy_clr),
    .live_stat (live_stat),
    .flag      (flag),
    .data_rdy  (data_rdy),
    .irq       (irq)
  );

  function automatic bit ref_hit(int s, int t, int m);
    if (m == 0) return s <= t;
    if (m == 1) return s >= t;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // model advances on the edge that samples the inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_live[i] = 1'b0;
        m_flag[i] = 1'b0;
      end
      m_rdy = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit h;
        h = ref_hit(int'($signed(smp_data)), int'(thr_a[i]), int'(mode_a[i]));
        if (smp_vld) m_live[i] = h;
        if (smp_vld && h) m_flag[i] = 1'b1;
        else if (flag_clr[i]) m_flag[i] = 1'b0;
      end
      if (smp_vld) m_rdy = 1'b1;
      else if (rdy_clr) m_rdy = 1'b0;
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      bit m_irq;
      m_irq = 1'b0;
      for (int i = 0; i < N; i++) begin
        chk(live_stat[i] == m_live[i], "R5 live", int'(live_stat[i]), int'(m_live[i]));
        chk(flag[i] == m_flag[i], "R6 flag", int'(flag[i]), int'(m_flag[i]));
        if (m_flag[i] && irq_en[i]) m_irq = 1'b1;
      end
      chk(data_rdy == m_rdy, "R9 rdy", int'(data_rdy), int'(m_rdy));
      chk(irq == m_irq, "R8 irq", int'(irq), int'(m_irq));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic sample(int v);
    smp_data = 16'(v);
    smp_vld  = 1'b1;
    tick();
    smp_vld  = 1'b0;
  endtask

  initial begin
    thr_a[0] = 16'sd100;  mode_a[0] = 2'd0;
    thr_a[1] = 16'sd100;  mode_a[1] = 2'd1;
    thr_a[2] = 16'sd100;  mode_a[2] = 2'd2;
    thr_a[3] = -16'sd300; mode_a[3] = 2'd3;
    thr_a[4] = -16'sd50;  mode_a[4] = 2'd0;
    thr_a[5] = -16'sd50;  mode_a[5] = 2'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    chk(live_stat == '0, "R1 live", int'(live_stat), 0);
    chk(flag == '0, "R1 flag", int'(flag), 0);
    chk(data_rdy == 1'b0, "R1 rdy", int'(data_rdy), 0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk_on = 1'b1;

    // equal-to-threshold sample: R2, R3 equality; R4 reserved; R10 sign
    sample(100);
    chk(live_stat[0] == 1'b1, "R2 equal", int'(live_stat[0]), 1);
    chk(live_stat[1] == 1'b1, "R3 equal", int'(live_stat[1]), 1);
    chk(live_stat[2] == 1'b0 && flag[2] == 1'b0, "R4 code2", int'(live_stat[2]), 0);
    chk(live_stat[3] == 1'b0 && flag[3] == 1'b0, "R4 code3", int'(live_stat[3]), 0);
    chk(live_stat[4] == 1'b0, "R10 pos vs neg LE", int'(live_stat[4]), 0);
    chk(live_stat[5] == 1'b1, "R10 pos vs neg GE", int'(live_stat[5]), 1);
    chk(data_rdy == 1'b1, "R9 set", int'(data_rdy), 1);

    // data moves without strobe: R5
    smp_data = 16'(-200);
    tick();
    tick();
    chk(live_stat == 6'b100011, "R5 hold", int'(live_stat), 'b100011);

    // negative sample: R2, R3, R6, R10
    sample(-200);
    chk(live_stat[0] == 1'b1, "R2 below", int'(live_stat[0]), 1);
    chk(live_stat[1] == 1'b0, "R3 below", int'(live_stat[1]), 0);
    chk(flag[1] == 1'b1, "R6 sticky", int'(flag[1]), 1);
    chk(live_stat[4] == 1'b1 && live_stat[5] == 1'b0, "R10 neg", int'(live_stat[5:4]), 1);
    chk(flag == 6'b110011, "R6 flags", int'(flag), 'b110011);

    // R8 gating
    irq_en = 6'b000010;
    #1 chk(irq == 1'b1, "R8 enabled", int'(irq), 1);
    irq_en = 6'b000000;
    #1 chk(irq == 1'b0, "R8 masked", int'(irq), 0);
    irq_en = 6'b000100;
    #1 chk(irq == 1'b0, "R8 flag low", int'(irq), 0);
    irq_en = 6'b000010;
    #1 chk(irq == 1'b1, "R8 rearm", int'(irq), 1);
    tick();

    // R7 clear, R11 independence
    flag_clr = 6'b000010;
    tick();
    flag_clr = '0;
    chk(flag[1] == 1'b0, "R7 clear", int'(flag[1]), 0);
    chk(flag == 6'b110001, "R11 others", int'(flag), 'b110001);
    chk(irq == 1'b0, "R8 after clear", int'(irq), 0);

    // R7 match wins over clear
    flag_clr = 6'b000001;
    sample(50);
    flag_clr = '0;
    chk(flag[0] == 1'b1, "R7 match wins", int'(flag[0]), 1);

    // R9 clear, and sample wins over clear
    rdy_clr = 1'b1;
    tick();
    chk(data_rdy == 1'b0, "R9 clear", int'(data_rdy), 0);
    sample(0);
    rdy_clr = 1'b0;
    chk(data_rdy == 1'b1, "R9 sample wins", int'(data_rdy), 1);

    // sweep of mixed patterns checked by the model
    mode_a[2] = 2'd1;
    mode_a[3] = 2'd0;
    for (int k = 0; k < 40; k++) begin
      smp_vld  = (k % 3) != 1;
      smp_data = 16'((k * 37) % 500 - 250);
      flag_clr = 6'(k * 5);
      rdy_clr  = (k % 4) == 0;
      irq_en   = 6'(k * 11);
      tick();
    end
    smp_vld = 1'b0;
    flag_clr = '0;
    rdy_clr = 1'b0;
    tick();
    chk_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule